// File: doc/BRIEF.md
# Predicate Prefix Controller

This block lets a small 16-bit microcoded processor run one instruction conditionally. A dedicated prefix instruction carries three condition bits. When the prefix is decoded, those bits are tested against the processor's current negative, zero and positive condition codes using the same rule that a conditional branch uses. The instruction that follows the prefix then either runs or is suppressed.

In both cases, the condition codes keep the values they held before the prefix. A guarded instruction may not load them, so one condition can guard several instructions in a row, each behind its own prefix. The block sits between the control store and the condition-code register. It takes the decoded instruction, the current flags, an instruction-complete strobe and the control store's raw condition-code load request. It returns a suppress-execute signal and the gated load enable. The PC still advances past a suppressed instruction, because the fetch path is not touched.

Top module: `pred_prefix_ctrl`

## Requirements
- R1: A clock edge with rst_n low returns the block to idle. In idle, exec_suppress is 0 and ldcc_gated follows ldcc_req.
- R2: An instruction is a prefix only when instr_valid is 1 and ir[15:12] equals 4'b1011. A decoded instruction with any other opcode never arms the block.
- R3: The prefix condition is (ir[11]&N)|(ir[10]&Z)|(ir[9]&P). The input cc_nzp carries N in bit 2, Z in bit 1 and P in bit 0. The condition is sampled in the cycle the prefix is decoded.
- R4: When the condition is true, the guarded instruction is not suppressed. ldcc_gated stays 0 from the cycle after the prefix decode through the guarded instruction's completion cycle.
- R5: When the condition is false, exec_suppress is 1 from the decode cycle of the next non-prefix instruction through its completion cycle. ldcc_gated is 0 over the same window.
- R6: Only one instruction is guarded. In the cycle after the guarded instruction's instr_done, the block is idle again.
- R7: A prefix decoded while a guard is pending re-evaluates the condition. The later prefix's condition decides the next instruction.
- R8: A guarded instruction whose instr_done arrives in its own decode cycle is handled for that cycle only. The block is idle in the next cycle.
- R9: With no pending prefix, a decoded instruction is never suppressed and ldcc_gated equals ldcc_req.
- R10: An instr_done that arrives while the guard is still waiting for its instruction (the prefix's own completion) does not end the guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | ir holds a newly decoded instruction this cycle |
| ir | input | 16 | Decoded instruction word |
| cc_nzp | input | 3 | Current condition codes {N,Z,P} |
| instr_done | input | 1 | Current instruction finishes this cycle |
| ldcc_req | input | 1 | Raw condition-code load request from the control store |
| exec_suppress | output | 1 | Squash the current instruction's side effects |
| ldcc_gated | output | 1 | Condition-code load enable after predicate gating |

## Verification
Both outputs are combinational functions of the registered guard state and the current inputs. A prefix decoded before clock edge k therefore shows up in the guarded instruction's decode cycle, right after edge k. A completion strobe before edge k releases the block, and ldcc_gated follows ldcc_req again right after that edge. The bench drives all inputs on the falling edge and samples 1 ns later, so each check reads the cycle it targets. The sweep covers all 64 pairings of condition bits and flags. It checks both outputs in the decode cycle, in the completion cycle and in the cycle after release.

// File: rtl/pp_pkg.sv
// Package: shared types and constants for the predicate prefix controller.
// Assumes a 16-bit instruction word with a 4-bit opcode in the top bits.
package pp_pkg;
    // Opcode value reserved for the predicate prefix.
    localparam logic [3:0] PP_PFX_OPC = 4'b1011;

    // Guard sequencer states.
    typedef enum logic [1:0] {
        PP_IDLE  = 2'd0,   // no prefix pending
        PP_ARMED = 2'd1,   // prefix decoded, waiting for the guarded instruction
        PP_GUARD = 2'd2    // guarded instruction in flight
    } pp_state_e;
endpackage

// File: rtl/pp_decode.sv
// Module: pp_decode
// Recognises the prefix opcode and evaluates its condition field against the
// flags. Purely combinational. Assumes the opcode sits in the top OPC_W bits
// of the field and the condition bits sit directly below it.
module pp_decode #(
    parameter int          OPC_W   = 4,
    parameter int          CC_W    = 3,
    parameter logic [OPC_W-1:0] PFX_OPC = 4'b1011,
    localparam int         FLD_W   = OPC_W + CC_W
) (
    input  logic             valid_i,
    input  logic [FLD_W-1:0] fld_i,     // {opcode, condition bits}
    input  logic [CC_W-1:0]  cc_i,
    output logic             pfx_hit_o,
    output logic             cond_o
);
    logic [CC_W-1:0] term;

    // Match the prefix opcode on a valid decode.
    always_comb pfx_hit_o = valid_i && (fld_i[FLD_W-1 -: OPC_W] == PFX_OPC);

    // One AND term per condition bit, like a branch test.
    for (genvar g = 0; g < CC_W; g++) begin : g_term
        assign term[g] = fld_i[g] & cc_i[g];
    end

    // Condition is true if any selected flag is set.
    always_comb cond_o = |term;

    // An empty selection can never be true.
    always_comb begin
        if (fld_i[CC_W-1:0] == '0) begin
            a_empty_false_r3: assert (!cond_o);
        end
    end
endmodule

// File: rtl/pp_seq.sv
// Module: pp_seq
// Holds the guard state and the skip flag. Arms on a prefix decode, captures
// the guarded instruction, and releases on that instruction's completion.
// Assumes the caller asserts done_i once per instruction.
module pp_seq
    import pp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid_i,
    input  logic      pfx_hit_i,
    input  logic      cond_i,
    input  logic      done_i,
    output pp_state_e st_o,
    output logic      suppress_o
);
    pp_state_e st_q, st_d;
    logic      skip_q, skip_d;
    logic      take_guard;

    // A non-prefix instruction decoded while armed is the guarded one.
    always_comb take_guard = (st_q == PP_ARMED) && valid_i && !pfx_hit_i;

    // Next-state and skip-flag logic.
    always_comb begin
        st_d   = st_q;
        skip_d = skip_q;
        if (pfx_hit_i) begin
            st_d   = PP_ARMED;
            skip_d = !cond_i;
        end else begin
            unique case (st_q)
                PP_ARMED: if (take_guard) st_d = done_i ? PP_IDLE : PP_GUARD;
                PP_GUARD: if (done_i)     st_d = PP_IDLE;
                default:                  st_d = PP_IDLE;
            endcase
        end
        if (st_d == PP_IDLE) skip_d = 1'b0;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PP_IDLE;
            skip_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            skip_q <= skip_d;
        end
    end

    // Suppress the guarded instruction over its whole life when skipping.
    always_comb suppress_o = skip_q && ((st_q == PP_GUARD) || take_guard);

    always_comb st_o = st_q;

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (st_q == PP_IDLE && !skip_q));
    p_arm_on_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_hit_i |=> st_q == PP_ARMED);
    p_skip_from_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_hit_i |=> skip_q == !$past(cond_i));
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PP_GUARD && done_i && !pfx_hit_i) |=> st_q == PP_IDLE);
    p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PP_ARMED && pfx_hit_i) |=> st_q == PP_ARMED);
    p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_guard && done_i) |=> st_q == PP_IDLE);
    p_armed_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PP_ARMED && !valid_i) |=> (st_q == PP_ARMED && $stable(skip_q)));
endmodule

// File: rtl/pp_cc_gate.sv
// Module: pp_cc_gate
// Blocks the control store's condition-code load while a guard is active.
// Assumes hold_i is high for the whole guard window.
module pp_cc_gate (
    input  logic ldcc_req_i,
    input  logic hold_i,
    output logic ldcc_o
);
    // Load passes only when no guard holds the flags.
    always_comb ldcc_o = ldcc_req_i && !hold_i;
endmodule

// File: rtl/pred_prefix_ctrl.sv
// Module: pred_prefix_ctrl
// Top level of the predicate prefix controller. Decodes the prefix, sequences
// the guard window, and gates the condition-code load. Assumes ir is stable
// while instr_valid is high.
module pred_prefix_ctrl
    import pp_pkg::*;
#(
    parameter int IR_W  = 16,
    parameter int OPC_W = 4,
    parameter int CC_W  = 3,
    localparam int FLD_W = OPC_W + CC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [IR_W-1:0] ir,
    input  logic [CC_W-1:0] cc_nzp,
    input  logic            instr_done,
    input  logic            ldcc_req,
    output logic            exec_suppress,
    output logic            ldcc_gated
);
    logic      pfx_hit, cond;
    pp_state_e st;
    logic      unused_ir_low;

    assign unused_ir_low = ^ir[IR_W-FLD_W-1:0];

    pp_decode #(.OPC_W(OPC_W), .CC_W(CC_W), .PFX_OPC(PP_PFX_OPC)) u_dec (
        .valid_i  (instr_valid),
        .fld_i    (ir[IR_W-1 -: FLD_W]),
        .cc_i     (cc_nzp),
        .pfx_hit_o(pfx_hit),
        .cond_o   (cond)
    );

    pp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (instr_valid),
        .pfx_hit_i (pfx_hit),
        .cond_i    (cond),
        .done_i    (instr_done),
        .st_o      (st),
        .suppress_o(exec_suppress)
    );

    pp_cc_gate u_gate (
        .ldcc_req_i(ldcc_req),
        .hold_i    (st != PP_IDLE),
        .ldcc_o    (ldcc_gated)
    );

    p_guard_blocks_cc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PP_IDLE) |-> !ldcc_gated);
    p_suppress_in_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_suppress |-> (st != PP_IDLE && !ldcc_gated));
    p_idle_transparent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PP_IDLE) |-> (!exec_suppress && ldcc_gated == ldcc_req));
endmodule

// File: tb/pred_prefix_ctrl_tb.sv
`timescale 1ns/1ps
module pred_prefix_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] ir = '0;
    logic [2:0]  cc_nzp = '0;
    logic        instr_done = 1'b0;
    logic        ldcc_req = 1'b0;
    logic        exec_suppress, ldcc_gated;
    int          n_checks = 0;
    int          n_errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    pred_prefix_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .ir(ir),
        .cc_nzp(cc_nzp), .instr_done(instr_done), .ldcc_req(ldcc_req),
        .exec_suppress(exec_suppress), .ldcc_gated(ldcc_gated)
    );

    // Directed vectors: {condition bits, flags, expected suppress}.
    localparam logic [6:0] VEC [8] = '{
        {3'b100, 3'b100, 1'b0}, {3'b010, 3'b100, 1'b1},
        {3'b001, 3'b001, 1'b0}, {3'b000, 3'b111, 1'b1},
        {3'b111, 3'b010, 1'b0}, {3'b110, 3'b001, 1'b1},
        {3'b011, 3'b010, 1'b0}, {3'b101, 3'b010, 1'b1}
    };

    task automatic check(input logic act, input logic exp, input string req,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Apply inputs on the falling edge, then wait for them to settle.
    task automatic drive(input logic v, input logic [15:0] w, input logic [2:0] f,
                         input logic req, input logic done);
        @(negedge clk);
        instr_valid = v; ir = w; cc_nzp = f; ldcc_req = req; instr_done = done;
        #1;
    endtask

    function automatic logic [15:0] pfx(input logic [2:0] bits);
        return {4'b1011, bits, 9'h0a5};
    endfunction

    localparam logic [15:0] ADD_W = 16'h1283;

    // Model of the branch-style test, one bit at a time.
    function automatic logic cond_model(input logic [2:0] b, input logic [2:0] f);
        logic r = 1'b0;
        if (b[2] && f[2]) r = 1'b1;
        if (b[1] && f[1]) r = 1'b1;
        if (b[0] && f[0]) r = 1'b1;
        return r;
    endfunction

    // Prefix, guarded two-cycle instruction, one idle cycle.
    task automatic run_guard(input logic [2:0] b, input logic [2:0] f,
                             input logic exp_sup, input string tag);
        drive(1, pfx(b), f, 0, 1);
        drive(1, ADD_W, ~f, 1, 0);
        check(exec_suppress, exp_sup, exp_sup ? "R5" : "R4", {tag, " decode suppress"});
        check(ldcc_gated, 1'b0, "R4", {tag, " decode ldcc"});
        drive(0, 16'h0, ~f, 1, 1);
        check(exec_suppress, exp_sup, exp_sup ? "R5" : "R4", {tag, " done suppress"});
        check(ldcc_gated, 1'b0, "R5", {tag, " done ldcc"});
        drive(0, 16'h0, f, 1, 0);
        check(exec_suppress, 1'b0, "R6", {tag, " released suppress"});
        check(ldcc_gated, 1'b1, "R6", {tag, " released ldcc"});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin : main
        drive(0, 16'h0, 3'b000, 1, 0);
        drive(0, 16'h0, 3'b000, 1, 0);
        rst_n = 1'b1;
        drive(0, 16'h0, 3'b000, 1, 0);
        check(exec_suppress, 1'b0, "R1", "reset suppress");
        check(ldcc_gated, 1'b1, "R1", "reset ldcc");

        for (int i = 0; i < 8; i++)
            run_guard(VEC[i][6:4], VEC[i][3:1], VEC[i][0], "R3 table");

        // Full sweep of condition bits against flags.
        for (int b = 0; b < 8; b++)
            for (int f = 0; f < 8; f++)
                run_guard(3'(b), 3'(f), !cond_model(3'(b), 3'(f)), "R3 sweep");

        // R9: plain instructions are transparent.
        drive(1, ADD_W, 3'b000, 1, 1);
        check(exec_suppress, 1'b0, "R9", "plain suppress");
        check(ldcc_gated, 1'b1, "R9", "plain ldcc");

        // R2: neighbouring opcode 1010 does not arm.
        drive(1, {4'b1010, 3'b111, 9'h0}, 3'b000, 0, 1);
        drive(1, ADD_W, 3'b000, 1, 1);
        check(exec_suppress, 1'b0, "R2", "non-prefix suppress");
        check(ldcc_gated, 1'b1, "R2", "non-prefix ldcc");

        // R7: false prefix overridden by a true one.
        drive(1, pfx(3'b100), 3'b010, 0, 1);
        drive(1, pfx(3'b010), 3'b010, 0, 1);
        drive(1, ADD_W, 3'b010, 1, 1);
        check(exec_suppress, 1'b0, "R7", "true after false");
        // R7: true prefix overridden by a false one.
        drive(1, pfx(3'b010), 3'b010, 0, 1);
        drive(1, pfx(3'b001), 3'b010, 0, 1);
        drive(1, ADD_W, 3'b010, 1, 0);
        check(exec_suppress, 1'b1, "R7", "false after true");
        drive(0, 16'h0, 3'b010, 1, 1);

        // R8: single-cycle guarded instruction.
        drive(1, pfx(3'b001), 3'b100, 0, 1);
        drive(1, ADD_W, 3'b100, 1, 1);
        check(exec_suppress, 1'b1, "R8", "single-cycle suppress");
        check(ldcc_gated, 1'b0, "R8", "single-cycle ldcc");
        drive(1, ADD_W, 3'b100, 1, 1);
        check(exec_suppress, 1'b0, "R8", "after single-cycle suppress");
        check(ldcc_gated, 1'b1, "R8", "after single-cycle ldcc");

        // R10: prefix completion strobe while armed keeps the guard.
        drive(1, pfx(3'b100), 3'b001, 0, 0);
        drive(0, 16'h0, 3'b001, 1, 1);
        check(ldcc_gated, 1'b0, "R10", "armed ldcc");
        drive(0, 16'h0, 3'b001, 0, 0);
        drive(1, ADD_W, 3'b001, 1, 1);
        check(exec_suppress, 1'b1, "R10", "guard survives done");

        // R1: reset while armed.
        drive(1, pfx(3'b100), 3'b001, 0, 1);
        rst_n = 1'b0;
        drive(0, 16'h0, 3'b001, 1, 0);
        rst_n = 1'b1;
        drive(1, ADD_W, 3'b001, 1, 1);
        check(exec_suppress, 1'b0, "R1", "reset clears guard");
        check(ldcc_gated, 1'b1, "R1", "reset clears hold");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule